// File: doc/BRIEF.md
# Flash command sequence decoder

This block is the command front end of a parallel NOR flash model. It watches the device bus: chip enable, output enable, write strobe, address and data. It recognises the multi-cycle unlock and command patterns that start an embedded operation: word program, chip erase or sector erase. The command latches have no place in the memory map. They exist only as the state of the decoder and the target registers it fills.

When a pattern completes, the block pulses a start strobe. It then holds a busy flag, a mode code, the target address and the target data for a separate array-operation engine. The engine answers with a one-cycle done pulse. While busy, reads on the bus return a status byte built from the operation in flight. When idle, reads pass the array data straight through. Any write that breaks a pattern sends the decoder back to idle read-array mode.

All bus inputs are sampled on the block clock. A write is taken on the first clock where the write strobe is seen high after being low.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, opBusy is 0, opMode is 0 (idle), opStart is 0, and rdData equals arrayRdData.
- R2: Four accepted writes start a word program: 0xAA at 0x555, 0x55 at 0x2AA, 0xA0 at 0x555, then any address/data pair. Unlock addresses compare only the low 11 address bits. On the clock edge that accepts the last write, opBusy becomes 1, opMode becomes 3, and opAddr/opData take the written pair. opStart is 1 for exactly that one cycle.
- R3: Six accepted writes start a chip erase with opMode 1: 0xAA at 0x555, 0x55 at 0x2AA, 0x80 at 0x555, 0xAA at 0x555, 0x55 at 0x2AA, then 0x10 at 0x555.
- R4: The same five-write prefix as R3, followed by 0x30 at any address, starts a sector erase with opMode 2. opAddr holds the address of that sixth write.
- R5: A write whose address/data pair is not the next expected one returns the decoder to idle. The remaining writes of the pattern then start nothing.
- R6: Data 0xF0, written while not busy at any address and at any point of a pattern (including the program data write), returns the decoder to idle and starts nothing.
- R7: While opBusy is 1, every write is ignored. opMode, opAddr and opData keep their values and opBusy stays 1.
- R8: A write is accepted only when chip enable is low and output enable is high at the rising edge of the write strobe. A write without these conditions leaves the pattern position unchanged.
- R9: An arrayDone pulse while busy clears opBusy and sets opMode to 0 on that clock edge. Afterwards rdData again equals arrayRdData.
- R10: While busy, rdData bit 7 is the complement of bit 7 of the target data. An erase uses all-ones target data, so bit 7 reads 0.
- R11: While busy, rdData bit 6 is 0 on the first read after start and inverts after each completed read. A read completes when output enable rises with chip enable low. During an erase, bit 2 follows bit 6. During a program, bit 2 is 0. All other status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| busCeN | input | 1 | Chip enable, active low |
| busOeN | input | 1 | Output enable, active low |
| busWeN | input | 1 | Write strobe, active low |
| busAddr | input | AW (18) | Bus address |
| busData | input | DW (8) | Bus write data |
| rdData | output | DW (8) | Read data: array data when idle, status when busy |
| arrayRdData | input | DW (8) | Data from the array |
| arrayDone | input | 1 | One-cycle pulse from the engine: operation finished |
| opStart | output | 1 | One-cycle pulse: operation begins |
| opBusy | output | 1 | Embedded operation in progress |
| opMode | output | 2 | 0 idle, 1 chip erase, 2 sector erase, 3 program |
| opAddr | output | AW (18) | Target address of the operation |
| opData | output | DW (8) | Target data (all ones for erase) |

## Verification
A wrong pattern position never shows at the ports by itself. It shows only at the write that ends a pattern: either opBusy rises one pattern too early, or it does not rise at all. The bench therefore completes a full sequence after every break, reset command or disqualified write, and checks opBusy at the clock edge of the last write. A stale target register or toggle bit shows on the first status read after opStart. Every operation is followed by two reads and a done handshake, so such a fault appears within a few cycles.

// File: rtl/fcsd_pkg.sv
package fcsd_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_CHIP = 2'd1,
    MODE_SECT = 2'd2,
    MODE_PROG = 2'd3
  } opMode_t;

  typedef struct packed {
    logic loadTarget;   // capture bus address/data into the target registers
    logic eraseTarget;  // the target is an erase (data forced to all ones)
    logic busy;         // embedded operation in flight
  } ctlStrobe_t;

  localparam logic [7:0] CODE_UNLK1 = 8'hAA;
  localparam logic [7:0] CODE_UNLK2 = 8'h55;
  localparam logic [7:0] CODE_ERSU  = 8'h80;
  localparam logic [7:0] CODE_PRGSU = 8'hA0;
  localparam logic [7:0] CODE_CHIP  = 8'h10;
  localparam logic [7:0] CODE_SECT  = 8'h30;
  localparam logic [7:0] CODE_RST   = 8'hF0;

  localparam logic [11:0] ADDR_UNLK1 = 12'h555;
  localparam logic [11:0] ADDR_UNLK2 = 12'h2AA;

endpackage

// File: rtl/fcsd_dpath.sv
module fcsd_dpath
  import fcsd_pkg::*;
#(
  parameter int AW     = 18,
  parameter int DW     = 8,
  parameter int CMD_AW = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busCeN,
  input  logic          busOeN,
  input  logic          busWeN,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busData,
  input  logic [DW-1:0] arrayRdData,
  input  ctlStrobe_t    strobe,
  output logic          wrEvt,
  output logic          addrIsA,
  output logic          addrIsB,
  output logic [DW-1:0] wrData,
  output logic [AW-1:0] opAddr,
  output logic [DW-1:0] opData,
  output logic [DW-1:0] rdData
);

  localparam logic [CMD_AW-1:0] MATCH_A = CMD_AW'(ADDR_UNLK1);
  localparam logic [CMD_AW-1:0] MATCH_B = CMD_AW'(ADDR_UNLK2);
  localparam int BIT_POLL = 7;
  localparam int BIT_TOG  = 6;
  localparam int BIT_ETOG = 2;

  logic weQ, oeQ;
  logic rdEnd;
  logic togQ;
  logic eraseQ;
  logic [DW-1:0] statusVec;

  // strobe history for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      weQ <= 1'b1;
      oeQ <= 1'b1;
    end else begin
      weQ <= busWeN;
      oeQ <= busOeN;
    end
  end

  assign wrEvt   = busWeN & ~weQ & ~busCeN & busOeN;
  assign rdEnd   = busOeN & ~oeQ & ~busCeN;
  assign addrIsA = (busAddr[CMD_AW-1:0] == MATCH_A);
  assign addrIsB = (busAddr[CMD_AW-1:0] == MATCH_B);
  assign wrData  = busData;

  // target latches
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opAddr <= '0;
      opData <= '1;
      eraseQ <= 1'b0;
    end else if (strobe.loadTarget) begin
      opAddr <= busAddr;
      opData <= strobe.eraseTarget ? {DW{1'b1}} : busData;
      eraseQ <= strobe.eraseTarget;
    end
  end

  // read toggle, advanced at the end of each read while busy
  always_ff @(posedge clk) begin
    if (!rstN) togQ <= 1'b0;
    else if (strobe.loadTarget) togQ <= 1'b0;
    else if (strobe.busy && rdEnd) togQ <= ~togQ;
  end

  // status byte, one bit at a time
  for (genvar b = 0; b < DW; b++) begin : g_status
    if (b == BIT_POLL) begin : g_poll
      assign statusVec[b] = ~opData[BIT_POLL];
    end else if (b == BIT_TOG) begin : g_tog
      assign statusVec[b] = togQ;
    end else if (b == BIT_ETOG) begin : g_etog
      assign statusVec[b] = togQ & eraseQ;
    end else begin : g_zero
      assign statusVec[b] = 1'b0;
    end
  end

  assign rdData = strobe.busy ? statusVec : arrayRdData;

  // R7
  tgt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.busy && !strobe.loadTarget) |=> ($stable(opAddr) && $stable(opData)));

  // R11
  tog_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadTarget |=> !rdData[BIT_TOG] || !strobe.busy);

endmodule

// File: rtl/fcsd_ctrl.sv
module fcsd_ctrl
  import fcsd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEvt,
  input  logic          addrIsA,
  input  logic          addrIsB,
  input  logic [DW-1:0] wrData,
  input  logic          arrayDone,
  output ctlStrobe_t    strobe,
  output logic          opStart,
  output logic [1:0]    opMode
);

  typedef enum logic [2:0] {
    S_IDLE, S_UNLK1, S_UNLK2, S_PRG, S_ERS1, S_ERS2, S_ERS3, S_BUSY
  } seqState_t;

  localparam logic [DW-1:0] D_UNLK1 = DW'(CODE_UNLK1);
  localparam logic [DW-1:0] D_UNLK2 = DW'(CODE_UNLK2);
  localparam logic [DW-1:0] D_ERSU  = DW'(CODE_ERSU);
  localparam logic [DW-1:0] D_PRGSU = DW'(CODE_PRGSU);
  localparam logic [DW-1:0] D_CHIP  = DW'(CODE_CHIP);
  localparam logic [DW-1:0] D_SECT  = DW'(CODE_SECT);
  localparam logic [DW-1:0] D_RST   = DW'(CODE_RST);

  seqState_t stateQ, stateN;
  opMode_t   modeQ, modeN;
  logic      loadN, eraseN;

  always_comb begin
    stateN = stateQ;
    modeN  = modeQ;
    loadN  = 1'b0;
    eraseN = 1'b0;
    if (stateQ == S_BUSY) begin
      if (arrayDone) begin
        stateN = S_IDLE;
        modeN  = MODE_IDLE;
      end
    end else if (wrEvt) begin
      if (wrData == D_RST) begin
        stateN = S_IDLE;
      end else begin
        stateN = S_IDLE;
        unique case (stateQ)
          S_IDLE:  if (addrIsA && wrData == D_UNLK1) stateN = S_UNLK1;
          S_UNLK1: if (addrIsB && wrData == D_UNLK2) stateN = S_UNLK2;
          S_UNLK2: begin
            if (addrIsA && wrData == D_PRGSU) stateN = S_PRG;
            else if (addrIsA && wrData == D_ERSU) stateN = S_ERS1;
          end
          S_PRG: begin
            stateN = S_BUSY;
            modeN  = MODE_PROG;
            loadN  = 1'b1;
          end
          S_ERS1:  if (addrIsA && wrData == D_UNLK1) stateN = S_ERS2;
          S_ERS2:  if (addrIsB && wrData == D_UNLK2) stateN = S_ERS3;
          S_ERS3: begin
            if (addrIsA && wrData == D_CHIP) begin
              stateN = S_BUSY;
              modeN  = MODE_CHIP;
              loadN  = 1'b1;
              eraseN = 1'b1;
            end else if (wrData == D_SECT) begin
              stateN = S_BUSY;
              modeN  = MODE_SECT;
              loadN  = 1'b1;
              eraseN = 1'b1;
            end
          end
          default: stateN = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= S_IDLE;
      modeQ   <= MODE_IDLE;
      opStart <= 1'b0;
    end else begin
      stateQ  <= stateN;
      modeQ   <= modeN;
      opStart <= loadN;
    end
  end

  assign strobe.loadTarget  = loadN;
  assign strobe.eraseTarget = eraseN;
  assign strobe.busy        = (stateQ == S_BUSY);
  assign opMode             = modeQ;

  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    opStart |=> !opStart);

  // R2
  start_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    opStart |-> (strobe.busy && opMode != MODE_IDLE));

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.busy && !arrayDone) |=> (strobe.busy && $stable(opMode)));

  // R9
  done_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.busy && arrayDone) |=> (!strobe.busy && opMode == MODE_IDLE));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcsd_pkg::*;
#(
  parameter int AW     = 18,
  parameter int DW     = 8,
  parameter int CMD_AW = 11
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busCeN,
  input  logic          busOeN,
  input  logic          busWeN,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busData,
  output logic [DW-1:0] rdData,
  input  logic [DW-1:0] arrayRdData,
  input  logic          arrayDone,
  output logic          opStart,
  output logic          opBusy,
  output logic [1:0]    opMode,
  output logic [AW-1:0] opAddr,
  output logic [DW-1:0] opData
);

  ctlStrobe_t    strobe;
  logic          wrEvt, addrIsA, addrIsB;
  logic [DW-1:0] wrData;

  fcsd_dpath #(.AW(AW), .DW(DW), .CMD_AW(CMD_AW)) dpath_i (
    .clk(clk), .rstN(rstN),
    .busCeN(busCeN), .busOeN(busOeN), .busWeN(busWeN),
    .busAddr(busAddr), .busData(busData), .arrayRdData(arrayRdData),
    .strobe(strobe),
    .wrEvt(wrEvt), .addrIsA(addrIsA), .addrIsB(addrIsB), .wrData(wrData),
    .opAddr(opAddr), .opData(opData), .rdData(rdData)
  );

  fcsd_ctrl #(.DW(DW)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .wrEvt(wrEvt), .addrIsA(addrIsA), .addrIsB(addrIsB), .wrData(wrData),
    .arrayDone(arrayDone),
    .strobe(strobe), .opStart(opStart), .opMode(opMode)
  );

  assign opBusy = strobe.busy;

endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busCeN = 1'b1, busOeN = 1'b1, busWeN = 1'b1;
  logic [17:0] busAddr = '0;
  logic [7:0]  busData = '0;
  logic [7:0]  rdData;
  logic [7:0]  arrayRdData = 8'h3C;
  logic        arrayDone = 1'b0;
  logic        opStart, opBusy;
  logic [1:0]  opMode;
  logic [17:0] opAddr;
  logic [7:0]  opData;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  flash_cmd_decoder dut_i (
    .clk(clk), .rstN(rstN), .busCeN(busCeN), .busOeN(busOeN), .busWeN(busWeN),
    .busAddr(busAddr), .busData(busData), .rdData(rdData),
    .arrayRdData(arrayRdData), .arrayDone(arrayDone),
    .opStart(opStart), .opBusy(opBusy), .opMode(opMode),
    .opAddr(opAddr), .opData(opData)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wrRaw(input logic [17:0] a, input logic [7:0] d, input logic ce, input logic oe);
    @(negedge clk);
    busAddr = a; busData = d; busCeN = ce; busOeN = oe; busWeN = 1'b0;
    @(negedge clk);
    busWeN = 1'b1;
    @(negedge clk);
    busCeN = 1'b1; busOeN = 1'b1;
  endtask

  task automatic wr(input logic [17:0] a, input logic [7:0] d);
    wrRaw(a, d, 1'b0, 1'b1);
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk);
    busCeN = 1'b0; busOeN = 1'b0;
    @(negedge clk);
    v = rdData;
    busOeN = 1'b1;
    @(negedge clk);
    busCeN = 1'b1;
  endtask

  task automatic seqProg(input logic [17:0] a, input logic [7:0] d, input logic [17:0] hi);
    wr(hi | 18'h555, 8'hAA);
    wr(hi | 18'h2AA, 8'h55);
    wr(hi | 18'h555, 8'hA0);
    wr(a, d);
  endtask

  task automatic erasePrefix();
    wr(18'h555, 8'hAA);
    wr(18'h2AA, 8'h55);
    wr(18'h555, 8'h80);
    wr(18'h555, 8'hAA);
    wr(18'h2AA, 8'h55);
  endtask

  task automatic finishOp(input string tag);
    @(negedge clk); arrayDone = 1'b1;
    @(negedge clk); arrayDone = 1'b0;
    chk({tag, " busy cleared"}, 32'(opBusy), 0);
    chk({tag, " mode idle"}, 32'(opMode), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog act=running exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [17:0] a;
    logic [7:0]  d;
    logic [17:0] hi;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(opBusy), 0);
    chk("R1 mode", 32'(opMode), 0);
    chk("R1 start", 32'(opStart), 0);
    chk("R1 passthrough", 32'(rdData), 32'h3C);

    // R2 / R10 / R11 / R9: program sweep
    for (int i = 0; i < 16; i++) begin
      a  = 18'((i * 18'h2345 + 7) & 18'h3FFFF);
      d  = 8'(i * 17);
      hi = (i % 2 == 1) ? 18'h3F800 : 18'h0;
      seqProg(a, d, hi);
      chk("R2 start", 32'(opStart), 1);
      chk("R2 busy", 32'(opBusy), 1);
      chk("R2 mode", 32'(opMode), 3);
      chk("R2 addr", 32'(opAddr), 32'(a));
      chk("R2 data", 32'(opData), 32'(d));
      @(negedge clk);
      chk("R2 start one cycle", 32'(opStart), 0);
      rd(v);
      chk("R10 R11 status first", 32'(v), 32'({~d[7], 7'b0}));
      rd(v);
      chk("R10 R11 status second", 32'(v), 32'({~d[7], 1'b1, 6'b0}));
      arrayRdData = d ^ 8'h5A;
      finishOp("R9 prog");
      rd(v);
      chk("R9 array data back", 32'(v), 32'(d ^ 8'h5A));
    end

    // R3 chip erase
    erasePrefix();
    wr(18'h555, 8'h10);
    chk("R3 busy", 32'(opBusy), 1);
    chk("R3 mode", 32'(opMode), 1);
    chk("R3 start", 32'(opStart), 1);
    chk("R10 erase data", 32'(opData), 32'hFF);
    rd(v); chk("R11 chip status first", 32'(v), 32'h00);
    rd(v); chk("R11 chip status second", 32'(v), 32'h44);
    rd(v); chk("R11 chip status third", 32'(v), 32'h00);
    finishOp("R9 chip");

    // R4 sector erase sweep
    for (int s = 0; s < 16; s++) begin
      a = 18'((s << 14) | (s * 3));
      erasePrefix();
      wr(a, 8'h30);
      chk("R4 busy", 32'(opBusy), 1);
      chk("R4 mode", 32'(opMode), 2);
      chk("R4 addr", 32'(opAddr), 32'(a));
      rd(v); chk("R11 sect status first", 32'(v), 32'h00);
      rd(v); chk("R11 sect status second", 32'(v), 32'h44);
      finishOp("R9 sect");
    end

    // R7 writes ignored while busy
    erasePrefix();
    wr(18'h0C000, 8'h30);
    seqProg(18'h01234, 8'h66, 18'h0);
    wr(18'h00100, 8'hF0);
    erasePrefix();
    wr(18'h555, 8'h10);
    chk("R7 busy held", 32'(opBusy), 1);
    chk("R7 mode held", 32'(opMode), 2);
    chk("R7 addr held", 32'(opAddr), 32'h0C000);
    chk("R7 data held", 32'(opData), 32'hFF);
    rd(v); chk("R7 status still erase", 32'(v), 32'h00);
    finishOp("R7");
    wr(18'h01234, 8'h66);
    chk("R7 no leftover pattern", 32'(opBusy), 0);

    // R5 break in a pattern
    wr(18'h555, 8'hAA);
    wr(18'h2AA, 8'h55);
    wr(18'h555, 8'h12);
    wr(18'h555, 8'hA0);
    wr(18'h00100, 8'h77);
    chk("R5 program break", 32'(opBusy), 0);
    wr(18'h555, 8'hAA);
    wr(18'h2AA, 8'h55);
    wr(18'h555, 8'h80);
    wr(18'h555, 8'hAA);
    wr(18'h123, 8'h55);
    wr(18'h2AA, 8'h55);
    wr(18'h555, 8'h10);
    chk("R5 erase break", 32'(opBusy), 0);
    erasePrefix();
    wr(18'h555, 8'h22);
    chk("R5 bad final code", 32'(opBusy), 0);
    seqProg(18'h00ABC, 8'h81, 18'h0);
    chk("R5 fresh pattern works", 32'(opBusy), 1);
    finishOp("R5");

    // R6 reset command
    wr(18'h555, 8'hAA);
    wr(18'h2AA, 8'h55);
    wr(18'h555, 8'hA0);
    wr(18'h00100, 8'hF0);
    chk("R6 reset at program data", 32'(opBusy), 0);
    wr(18'h00100, 8'h99);
    chk("R6 decoder idle after reset", 32'(opBusy), 0);
    wr(18'h555, 8'hAA);
    wr(18'h2AA, 8'h55);
    wr(18'h555, 8'h80);
    wr(18'h3FFFF, 8'hF0);
    wr(18'h555, 8'hAA);
    wr(18'h2AA, 8'h55);
    wr(18'h555, 8'h10);
    chk("R6 reset inside erase prefix", 32'(opBusy), 0);

    // R8 write qualification
    wr(18'h555, 8'hAA);
    wrRaw(18'h00000, 8'h00, 1'b1, 1'b1);
    wr(18'h2AA, 8'h55);
    wrRaw(18'h00000, 8'h00, 1'b0, 1'b0);
    wr(18'h555, 8'hA0);
    wr(18'h01234, 8'h5C);
    chk("R8 disqualified writes skipped", 32'(opBusy), 1);
    chk("R8 addr", 32'(opAddr), 32'h01234);
    finishOp("R8");
    wrRaw(18'h555, 8'hAA, 1'b1, 1'b1);
    wrRaw(18'h2AA, 8'h55, 1'b1, 1'b1);
    wrRaw(18'h555, 8'hA0, 1'b1, 1'b1);
    wrRaw(18'h00200, 8'h11, 1'b1, 1'b1);
    chk("R8 chip disabled", 32'(opBusy), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule